// File: doc/BRIEF.md
# Lane-Compacting Stream Width Down-Converter

This block sits between a wide producer and a narrow consumer. Each wide word carries a fixed number of equal-width lane words and one enable bit per lane. The block hands the lanes out one per narrow transfer. Lanes whose enable bit is clear carry no meaningful data, so the block skips them: it never spends an output transfer on them. Both sides use a valid/ready handshake, and a transfer happens only in a cycle where both signals are high.

The block holds one wide word in a register, together with a mask of the enabled lanes that have not yet been sent. The output is driven only from that stored state. Output valid therefore never depends on output ready in the same cycle. The input side is combinational in output ready only: it accepts a new word in the same cycle that the last remaining lane leaves. A steady stream of wide words therefore passes with no idle cycle between them.

Top module: `lane_downsizer`

## Requirements
- R1: Lane k of the wide input occupies bits [k*LANE_W +: LANE_W] of `in_lanes`, and bit k of `in_en` enables lane k. The default is LANES=4 and LANE_W=8.
- R2: A lane whose enable bit is clear is never presented on `out_lane` with `out_valid` high.
- R3: The enabled lanes of one wide word leave in ascending lane index order, lowest index first. Words leave in the order they were accepted.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high in the next cycle and `out_lane` stays unchanged.
- R5: `out_valid` goes from low to high only in the cycle after an input transfer whose enable field is nonzero. `out_ready` alone never raises it.
- R6: While `rst` is high, and in the first cycle after it, `out_valid` is low and `in_ready` is high.
- R7: An input word is taken only in a cycle with `in_valid` and `in_ready` both high. A lane is consumed only in a cycle with `out_valid` and `out_ready` both high.
- R8: `in_ready` is high exactly when no enabled lane is pending, or when the single remaining lane is transferring in that same cycle. This allows back-to-back words with no bubble.
- R9: A wide word with all enable bits clear is accepted and dropped, and it produces no output transfer.
- R10: After an input transfer with a nonzero enable field, `out_valid` is high in the next cycle and `out_lane` shows the lowest enabled lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_lanes | input | LANES*LANE_W | Packed lane words of the wide input |
| in_en | input | LANES | Per-lane enable bits |
| in_valid | input | 1 | Wide word offered |
| in_ready | output | 1 | Wide word can be taken this cycle |
| out_lane | output | LANE_W | Current narrow lane word |
| out_valid | output | 1 | Narrow lane word offered |
| out_ready | input | 1 | Consumer takes the lane this cycle |

## Verification
Every result is due one clock edge after the handshake that causes it. An accepted word shows its first enabled lane, with `out_valid` high, after the edge on which the word was taken. Each consumed lane advances `out_lane` to the next enabled lane, or drops `out_valid`, after that same edge. `in_ready` is combinational and belongs to the current cycle. The bench drives its inputs just after the falling edge. It evaluates both handshakes one nanosecond before the rising edge, so each prediction made there is compared against the ports at the same point of the following cycle.

// File: rtl/lane_downsizer.sv
module lane_downsizer #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*LANE_W-1:0] in_lanes,
  input  logic [LANES-1:0]        in_en,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic [LANE_W-1:0]       out_lane,
  output logic                    out_valid,
  input  logic                    out_ready
);

  logic [LANES*LANE_W-1:0] word_q;
  logic [LANES-1:0]        left_q;
  logic [LANES-1:0]        low_oh;
  logic [IDX_W-1:0]        sel;
  logic                    last_one;
  logic                    out_fire;
  logic                    in_fire;

  always_comb begin
    sel = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (left_q[i]) sel = IDX_W'(i);
  end

  assign low_oh    = left_q & (~left_q + 1'b1);
  assign last_one  = (left_q == low_oh);
  assign out_valid = |left_q;
  assign out_lane  = word_q[sel*LANE_W +: LANE_W];
  assign out_fire  = out_valid & out_ready;
  assign in_ready  = ~out_valid | (out_fire & last_one);
  assign in_fire   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst)
      left_q <= '0;
    else if (in_fire)
      left_q <= in_en;
    else if (out_fire)
      left_q <= left_q & ~low_oh;
  end

  always_ff @(posedge clk) begin
    if (in_fire) word_q <= in_lanes;
  end

endmodule

// File: rtl/lane_downsizer_chk.sv
module lane_downsizer_chk #(
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LANE_W-1:0] out_lane,
  input logic              out_valid,
  input logic              out_ready
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(negedge clk)
    if (rst_d === 1'b1) begin
      AST_RESET_QUIET: assert (!out_valid && in_ready) else $error("reset state"); // R6
    end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid); // R4

  AST_HOLD_LANE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_lane)); // R4

  AST_NO_READY_WAKE: assert property (@(posedge clk) disable iff (rst)
    !out_valid && !(in_valid && in_ready) |=> !out_valid); // R5

  AST_IDLE_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R8

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R8

endmodule

bind lane_downsizer lane_downsizer_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_lane(out_lane), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/sim_lane_downsizer.sv
`timescale 1ns/1ps
module sim_lane_downsizer;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES*LANE_W-1:0] in_lanes = '0;
  logic [LANES-1:0]        in_en = '0;
  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic [LANE_W-1:0]       out_lane;
  logic                    out_valid;
  logic                    out_ready = 1'b0;

  always #4 clk = ~clk;

  lane_downsizer #(.LANES(LANES), .LANE_W(LANE_W)) u0 (
    .clk(clk), .rst(rst), .in_lanes(in_lanes), .in_en(in_en),
    .in_valid(in_valid), .in_ready(in_ready), .out_lane(out_lane),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [LANE_W-1:0] sb[$];
  bit stall_prev = 0;
  logic [LANE_W-1:0] lane_prev;
  bit want_low = 0;
  bit want_high = 0;
  logic [LANE_W-1:0] want_first;
  bit taken = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // inputs already set after the falling edge; evaluate 1 ns before rising edge
  task automatic tick();
    bit exp_rdy;
    #3;
    if (want_low)  chk(out_valid == 1'b0, "R5 no spontaneous valid", out_valid, 0);
    if (want_high) begin
      chk(out_valid == 1'b1, "R10 valid after accept", out_valid, 1);
      chk(out_lane == want_first, "R10 first lane", out_lane, want_first);
    end
    if (stall_prev) begin
      chk(out_valid == 1'b1, "R4 valid held", out_valid, 1);
      chk(out_lane == lane_prev, "R4 lane held", out_lane, lane_prev);
    end
    exp_rdy = (sb.size() == 0) || (sb.size() == 1 && out_ready);
    chk(in_ready == exp_rdy, "R8 in_ready", in_ready, exp_rdy);
    chk(out_valid == (sb.size() != 0), "R7 out_valid vs pending", out_valid, sb.size() != 0);
    taken = 0;
    want_low = 0;
    want_high = 0;
    if (out_valid && out_ready) begin
      if (sb.size() == 0) chk(0, "R2 unexpected lane", out_lane, 0);
      else begin
        chk(out_lane == sb[0], "R3 lane order", out_lane, sb[0]);
        void'(sb.pop_front());
      end
    end
    if (in_valid && in_ready) begin
      taken = 1;
      // R1: lane k at bits k*LANE_W, enable bit k
      for (int k = 0; k < LANES; k++)
        if (in_en[k]) sb.push_back(in_lanes[k*LANE_W +: LANE_W]);
      if (in_en != 0) begin
        want_high = 1;
        want_first = sb[0];
      end else want_low = 1;
    end else if (!out_valid) want_low = 1;
    stall_prev = out_valid && !out_ready;
    lane_prev = out_lane;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R6 reset valid", out_valid, 0);
    chk(in_ready == 1'b1, "R6 reset ready", in_ready, 1);
    rst = 1'b0;
    #3;
    chk(out_valid == 1'b0 && in_ready, "R6 after reset", {out_valid, in_ready}, 2'b01);
    @(negedge clk);

    // R5: ready alone never raises valid
    out_ready = 1'b1;
    repeat (4) tick();

    // R9: all-zero enable word dropped
    in_valid = 1'b1; in_en = '0; in_lanes = 32'hAABBCCDD;
    tick();
    in_valid = 1'b0;
    tick();
    chk(out_valid == 1'b0 && sb.size() == 0, "R9 empty word dropped", out_valid, 0);

    // R2/R3: sparse and full enables under stall
    out_ready = 1'b0;
    in_valid = 1'b1; in_en = 4'b1010; in_lanes = 32'h44332211;
    tick();
    in_valid = 1'b0;
    tick(); tick();
    chk(out_lane == 8'h22, "R2 skip lane 0", out_lane, 8'h22);
    out_ready = 1'b1;
    repeat (3) tick();

    // R8: back-to-back single-lane words, no bubble
    for (int n = 0; n < 6; n++) begin
      in_valid = 1'b1; in_en = 4'b0100; in_lanes = {8'h00, 8'(8'h60 + n), 16'h0};
      tick();
      if (n > 0) chk(taken == 1, "R8 back-to-back", taken, 1);
    end
    in_valid = 1'b0;
    repeat (3) tick();

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      if (!in_valid || taken) begin
        in_valid = ($urandom % 4) != 0;
        in_lanes = $urandom;
        in_en = (($urandom % 8) == 0) ? '0 : LANES'($urandom);
      end
      out_ready = ($urandom % 3) != 0;
      tick();
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (8) tick();
    chk(sb.size() == 0, "R3 all lanes delivered", sb.size(), 0);
    finish_up();
  end
endmodule